// File: doc/BRIEF.md
# Predicate Redirection and Masking Unit

This block turns a destination register number and the current vector length into a per-element write-enable mask and a zero-or-skip policy bit. It holds a small associative table that maps destination register numbers to predicate sources. When a request arrives, the table is searched for the register. A hit names an integer register whose bits form the predicate, one bit per element. The unit reads that register through an external read port and complements every bit if the entry asks for it. It then clears all bits at and above the vector length, and passes on the entry's zeroing choice together with the mask.

The element loop uses the result to decide which lanes are written. Disabled lanes are either written with zero or left alone, depending on the zeroing bit. A register with no table entry is treated as fully enabled up to the vector length. In that case the zeroing bit is off. The table is loaded one entry at a time through a write port. The lookup and the register read happen in the request cycle, and the mask and policy come out of a register one cycle later.

Top module: `pred_redirect_unit`

## Requirements
- R1: After reset, out_valid, out_mask and out_zero are 0 and every table entry is invalid, so every later lookup behaves as a miss until an entry is written.
- R2: out_valid is high in exactly the cycle after a cycle with req_valid high. out_mask and out_zero in that cycle belong to that request.
- R3: On a hit, rf_raddr carries the entry's source register index in the request cycle. The output mask bits below the vector length equal the bits of rf_rdata, with bit i giving element i.
- R4: When the hitting entry's invert bit is 1, every bit of the fetched predicate is complemented before the length limit is applied.
- R5: On a hit, out_zero equals the entry's zeroing bit (1 = disabled elements are written with zero, 0 = disabled elements are skipped).
- R6: Mask bits at positions greater than or equal to req_vl are 0. A req_vl of XLEN or larger enables all XLEN positions.
- R7: On a miss, rf_raddr is 0, out_mask has ones exactly below req_vl, and out_zero is 0.
- R8: When several valid entries carry the same key, the entry with the highest table index decides the source, inversion and zeroing.
- R9: A source index of 0 reads as an all-zero predicate whatever rf_rdata holds. The mask is therefore all disabled, or all enabled below req_vl when the invert bit is set.
- R10: An entry whose valid bit is 0 never hits. A table write at one clock edge affects requests from the next cycle on.
- R11: In a cycle after one with req_valid low, out_mask and out_zero keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_we | input | 1 | Write one table entry |
| tbl_idx | input | $clog2(ENTRIES) | Entry number to write |
| tbl_valid | input | 1 | Valid bit of the written entry |
| tbl_key | input | 5 | Destination register number the entry matches |
| tbl_src | input | 5 | Integer register holding the predicate |
| tbl_inv | input | 1 | Complement the whole predicate |
| tbl_zero | input | 1 | Zero (1) or skip (0) disabled elements |
| req_valid | input | 1 | Lookup request |
| req_reg | input | 5 | Destination register number to look up |
| req_vl | input | $clog2(XLEN+1) | Current vector length |
| rf_raddr | output | 5 | Integer register read address |
| rf_rdata | input | XLEN | Integer register read data, same cycle |
| out_valid | output | 1 | Result valid |
| out_mask | output | XLEN | Per-element enable mask |
| out_zero | output | 1 | Zeroing policy for disabled elements |

## Verification
The assertions rely on the register read port returning data in the same cycle as rf_raddr, and on req_vl possibly exceeding XLEN, which the mask must tolerate. The stimulus drives all inputs half a period away from the clock edge. It keeps keys and looked-up registers in a narrow range, so that hits, misses, duplicate keys and invalid entries all occur often. Vector lengths are drawn from zero to a few past XLEN. The bench register model returns a nonzero value for register 0, so the forced-zero rule is actually exercised.

// File: rtl/pred_pkg.sv
package pred_pkg;

    localparam int REG_AW = 5;

    typedef logic [REG_AW-1:0] reg_idx_t;

    typedef struct packed {
        logic     valid;
        reg_idx_t key;
        reg_idx_t src;
        logic     inv;
        logic     zero;
    } pred_entry_t;

    typedef struct packed {
        logic     hit;
        reg_idx_t src;
        logic     inv;
        logic     zero;
    } pred_hit_t;

    function automatic pred_hit_t entry_to_hit(pred_entry_t e);
        pred_hit_t h;
        h.hit  = 1'b1;
        h.src  = e.src;
        h.inv  = e.inv;
        h.zero = e.zero;
        return h;
    endfunction

endpackage

// File: rtl/pred_table.sv
module pred_table
    import pred_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDXW = $clog2(ENTRIES)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [IDXW-1:0] wr_idx,
    input  pred_entry_t wr_entry,
    input  reg_idx_t    lk_key,
    output pred_hit_t   lk_hit
);

    pred_entry_t slots [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slots[g] <= '0;
            end else if (wr_en && wr_idx == IDXW'(g)) begin
                slots[g] <= wr_entry;
            end
        end
    end

    // ascending scan: a later (higher) index overrides earlier matches
    always_comb begin
        lk_hit = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (slots[i].valid && slots[i].key == lk_key) begin
                lk_hit = entry_to_hit(slots[i]);
            end
        end
    end

endmodule

// File: rtl/pred_source.sv
module pred_source
    import pred_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  pred_hit_t       hit,
    input  logic [XLEN-1:0] rf_rdata,
    output reg_idx_t        rf_raddr,
    output logic [XLEN-1:0] bits
);

    logic [XLEN-1:0] fetched;

    always_comb begin
        rf_raddr = hit.hit ? hit.src : '0;
        fetched  = (hit.src == '0) ? '0 : rf_rdata;
        if (!hit.hit) begin
            bits = '1;
        end else if (hit.inv) begin
            bits = ~fetched;
        end else begin
            bits = fetched;
        end
    end

endmodule

// File: rtl/pred_limit.sv
module pred_limit #(
    parameter int XLEN = 64,
    localparam int VLW = $clog2(XLEN + 1)
) (
    input  logic [XLEN-1:0] bits_in,
    input  logic [VLW-1:0]  vl,
    output logic [XLEN-1:0] bits_out
);

    for (genvar b = 0; b < XLEN; b++) begin : g_lane
        assign bits_out[b] = bits_in[b] & (vl > VLW'(b));
    end

endmodule

// File: rtl/pred_redirect_unit.sv
module pred_redirect_unit
    import pred_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter int ENTRIES = 16,
    localparam int VLW  = $clog2(XLEN + 1),
    localparam int IDXW = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tbl_we,
    input  logic [IDXW-1:0]   tbl_idx,
    input  logic              tbl_valid,
    input  logic [REG_AW-1:0] tbl_key,
    input  logic [REG_AW-1:0] tbl_src,
    input  logic              tbl_inv,
    input  logic              tbl_zero,
    input  logic              req_valid,
    input  logic [REG_AW-1:0] req_reg,
    input  logic [VLW-1:0]    req_vl,
    output logic [REG_AW-1:0] rf_raddr,
    input  logic [XLEN-1:0]   rf_rdata,
    output logic              out_valid,
    output logic [XLEN-1:0]   out_mask,
    output logic              out_zero
);

    pred_entry_t     wr_entry;
    pred_hit_t       hit;
    logic [XLEN-1:0] pred_bits;
    logic [XLEN-1:0] limited;

    always_comb begin
        wr_entry.valid = tbl_valid;
        wr_entry.key   = tbl_key;
        wr_entry.src   = tbl_src;
        wr_entry.inv   = tbl_inv;
        wr_entry.zero  = tbl_zero;
    end

    pred_table #(.ENTRIES(ENTRIES)) u_table (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (tbl_we),
        .wr_idx   (tbl_idx),
        .wr_entry (wr_entry),
        .lk_key   (req_reg),
        .lk_hit   (hit)
    );

    pred_source #(.XLEN(XLEN)) u_source (
        .hit      (hit),
        .rf_rdata (rf_rdata),
        .rf_raddr (rf_raddr),
        .bits     (pred_bits)
    );

    pred_limit #(.XLEN(XLEN)) u_limit (
        .bits_in  (pred_bits),
        .vl       (req_vl),
        .bits_out (limited)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_mask  <= '0;
            out_zero  <= 1'b0;
        end else begin
            out_valid <= req_valid;
            if (req_valid) begin
                out_mask <= limited;
                out_zero <= hit.hit & hit.zero;
            end
        end
    end

endmodule

// File: rtl/pred_redirect_checker.sv
module pred_redirect_checker #(
    parameter int XLEN = 64,
    localparam int VLW = $clog2(XLEN + 1)
) (
    input logic            clk,
    input logic            rst,
    input logic            req_valid,
    input logic [VLW-1:0]  req_vl,
    input logic [4:0]      rf_raddr,
    input logic            out_valid,
    input logic [XLEN-1:0] out_mask,
    input logic            out_zero
);

    p_valid_follows_r2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> out_valid);

    p_idle_follows_r2: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !out_valid);

    p_above_len_clear_r6: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> ((out_mask >> $past(req_vl)) == '0));

    p_count_bound_r6: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> ($countones(out_mask) <= $past(req_vl)));

    p_src_zero_uniform_r9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && rf_raddr == '0) |=>
            (out_mask == '0 || (out_mask >> $past(req_vl)) == '0 &&
             $countones(out_mask) == (($past(req_vl) > VLW'(XLEN)) ? XLEN : int'($past(req_vl)))));

    p_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> ($stable(out_mask) && $stable(out_zero)));

endmodule

bind pred_redirect_unit pred_redirect_checker #(.XLEN(XLEN)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_vl    (req_vl),
    .rf_raddr  (rf_raddr),
    .out_valid (out_valid),
    .out_mask  (out_mask),
    .out_zero  (out_zero)
);

// File: tb/pred_redirect_unit_bench.sv
`timescale 1ns/1ps
module pred_redirect_unit_bench;

    localparam int XLEN = 64;
    localparam int ENTRIES = 16;
    localparam int VLW = $clog2(XLEN + 1);
    localparam int IDXW = $clog2(ENTRIES);

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic            tbl_we = 0;
    logic [IDXW-1:0] tbl_idx = '0;
    logic            tbl_valid = 0;
    logic [4:0]      tbl_key = '0;
    logic [4:0]      tbl_src = '0;
    logic            tbl_inv = 0;
    logic            tbl_zero = 0;
    logic            req_valid = 0;
    logic [4:0]      req_reg = '0;
    logic [VLW-1:0]  req_vl = '0;
    logic [4:0]      rf_raddr;
    logic [XLEN-1:0] rf_rdata;
    logic            out_valid;
    logic [XLEN-1:0] out_mask;
    logic            out_zero;

    logic [XLEN-1:0] bregs [32];
    assign rf_rdata = bregs[rf_raddr];

    pred_redirect_unit #(.XLEN(XLEN), .ENTRIES(ENTRIES)) u_pred_redirect_unit (
        .clk(clk), .rst(rst), .tbl_we(tbl_we), .tbl_idx(tbl_idx),
        .tbl_valid(tbl_valid), .tbl_key(tbl_key), .tbl_src(tbl_src),
        .tbl_inv(tbl_inv), .tbl_zero(tbl_zero), .req_valid(req_valid),
        .req_reg(req_reg), .req_vl(req_vl), .rf_raddr(rf_raddr),
        .rf_rdata(rf_rdata), .out_valid(out_valid), .out_mask(out_mask),
        .out_zero(out_zero)
    );

    // bench table model
    logic       m_valid [ENTRIES];
    logic [4:0] m_key   [ENTRIES];
    logic [4:0] m_src   [ENTRIES];
    logic       m_inv   [ENTRIES];
    logic       m_zero  [ENTRIES];

    int total = 0;
    int bad = 0;

    task automatic check(input bit ok, input string req, input logic [XLEN-1:0] act,
                         input logic [XLEN-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [XLEN-1:0] len_ones(input int vl);
        if (vl >= XLEN) return '1;
        return (64'd1 << vl) - 64'd1;
    endfunction

    function automatic int find_hit(input logic [4:0] r);
        int w = -1;
        for (int i = 0; i < ENTRIES; i++)
            if (m_valid[i] && m_key[i] == r) w = i;
        return w;
    endfunction

    task automatic wr(input int idx, input bit v, input int key, input int src,
                      input bit inv, input bit zero);
        @(negedge clk);
        tbl_we = 1; tbl_idx = IDXW'(idx); tbl_valid = v; tbl_key = 5'(key);
        tbl_src = 5'(src); tbl_inv = inv; tbl_zero = zero;
        @(negedge clk);
        tbl_we = 0;
        m_valid[idx] = v; m_key[idx] = 5'(key); m_src[idx] = 5'(src);
        m_inv[idx] = inv; m_zero[idx] = zero;
    endtask

    // issue one lookup and check address, mask and zero flag
    task automatic lookup(input int r, input int vl, input string tag);
        int w;
        logic [XLEN-1:0] p;
        logic [XLEN-1:0] em;
        logic ez;
        logic [4:0] ea;
        w = find_hit(5'(r));
        if (w < 0) begin
            ea = 0; em = len_ones(vl); ez = 0;
        end else begin
            ea = m_src[w];
            p = (m_src[w] == 0) ? '0 : bregs[m_src[w]];
            if (m_inv[w]) p = ~p;
            em = p & len_ones(vl);
            ez = m_zero[w];
        end
        req_valid = 1; req_reg = 5'(r); req_vl = VLW'(vl);
        #0.5;
        check(rf_raddr == ea, {tag, " raddr"}, XLEN'(rf_raddr), XLEN'(ea));
        @(negedge clk);
        req_valid = 0;
        check(out_valid == 1'b1, "R2 valid", XLEN'(out_valid), 1);
        check(out_mask == em, {tag, " mask"}, out_mask, em);
        check(out_zero == ez, {tag, " zero"}, XLEN'(out_zero), XLEN'(ez));
    endtask

    initial begin : watchdog
        #400000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [XLEN-1:0] held_m;
        logic held_z;
        void'($urandom(32'h1234abcd));
        for (int i = 0; i < 32; i++) bregs[i] = {$urandom, $urandom};
        bregs[0] = 64'hdead_beef_0bad_f00d;
        for (int i = 0; i < ENTRIES; i++) begin
            m_valid[i] = 0; m_key[i] = 0; m_src[i] = 0; m_inv[i] = 0; m_zero[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        check(out_valid == 0, "R1 valid", XLEN'(out_valid), 0);
        check(out_mask == 0, "R1 mask", out_mask, 0);
        check(out_zero == 0, "R1 zero", XLEN'(out_zero), 0);
        @(negedge clk);
        lookup(5, 20, "R1 R7");
        lookup(7, XLEN, "R7");
        // R3 plain hit, R5 zero flag
        wr(0, 1, 3, 9, 0, 1);
        lookup(3, XLEN, "R3 R5");
        lookup(3, 17, "R3 R6");
        // R4 invert
        wr(1, 1, 4, 9, 1, 0);
        lookup(4, XLEN, "R4");
        // R6 length beyond XLEN and zero length
        lookup(4, XLEN + 5, "R6");
        lookup(4, 0, "R6");
        // R8 duplicate key, higher index wins
        wr(5, 1, 3, 11, 1, 0);
        lookup(3, 40, "R8");
        // R9 register zero source
        wr(6, 1, 8, 0, 0, 1);
        lookup(8, XLEN, "R9");
        wr(6, 1, 8, 0, 1, 1);
        lookup(8, 33, "R9");
        // R10 invalid entry does not hit; write then immediate use
        wr(2, 0, 12, 13, 0, 1);
        lookup(12, XLEN, "R10");
        wr(2, 1, 12, 13, 0, 1);
        lookup(12, XLEN, "R10");
        // R11 hold during idle cycles
        held_m = out_mask; held_z = out_zero;
        repeat (3) @(negedge clk);
        check(out_valid == 0, "R2 idle", XLEN'(out_valid), 0);
        check(out_mask == held_m, "R11 mask", out_mask, held_m);
        check(out_zero == held_z, "R11 zero", XLEN'(out_zero), XLEN'(held_z));
        // random mix
        for (int it = 0; it < 400; it++) begin
            if ($urandom_range(0, 3) == 0) begin
                wr($urandom_range(0, ENTRIES - 1), $urandom_range(0, 4) != 0,
                   $urandom_range(0, 7), $urandom_range(0, 31),
                   1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
            end
            bregs[$urandom_range(1, 31)] = {$urandom, $urandom};
            lookup($urandom_range(0, 9), $urandom_range(0, XLEN + 3), "R3 R4 R6 R8");
            if ($urandom_range(0, 4) == 0) @(negedge clk);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule